// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit forms data-memory addresses for a 16-bit DSP-style core. For each accepted operation it takes a decoded addressing-mode code, a register select, a 16-bit long operand and a 6-bit short field. It returns the effective address and, for the modes that update a pointer, the new pointer value that is written back. It also handles direct loads of its own registers. It holds four pointer registers (R0 to R3), a stack pointer, an offset register and a modifier register. The modifier register gives modulo (circular-buffer) arithmetic on the two lowest pointers.

Results are registered. An operation presented with `op_valid` high at a rising clock edge shows its address, write-back and illegal flag on the outputs from that edge until the next one. Any register update happens at the same edge. Instruction decode, the memories, the hardware stack and the data ALU sit outside the block.

Top module: `dsp_agu`

## Requirements
- R1: I/O short mode (mode code 9) outputs the 6-bit short field with the 10 upper bits forced to one, giving an address from 0xFFC0 to 0xFFFF, whatever `rsel` holds; it writes back nothing.
- R2: Plain indirect mode (code 0) outputs the selected pointer as the address and leaves it unchanged; `rsel` 0 to 3 picks R0 to R3, 4 picks the stack pointer.
- R3: Post-increment (code 1), post-decrement (code 2) and post-add-offset (code 3) output the current pointer as the address, then write back pointer+1, pointer-1 or pointer+N.
- R4: Indexed-by-offset mode (code 4) outputs pointer+N as the address and writes back nothing.
- R5: Short-displacement mode (code 5) is legal only with `rsel`=2 (address R2 plus the zero-extended short field) or `rsel`=4 (address SP minus the zero-extended short field). It never uses modulo arithmetic and writes back nothing.
- R6: Long-displacement mode (code 6) outputs the pointer or SP plus the 16-bit `disp` operand and writes back nothing.
- R7: When M01 is 0xFFFF the arithmetic is linear. Otherwise the modulus is M01+1. For codes 1, 3, 4 and 6 on R0 or R1, a result that leaves the buffer wraps back into it, inside a block aligned to the smallest power of two that is not below the modulus.
- R8: Modulo arithmetic never applies to R2, R3 or SP, nor to post-decrement or short-displacement modes; these stay linear while M01 is not 0xFFFF.
- R9: Absolute mode (code 7) outputs `disp` as the address. Absolute-short mode (code 8) outputs the short field zero-extended.
- R10: Register-load mode (code 10) writes `disp` into the register picked by `rsel`: 0 to 3 R0 to R3, 4 SP, 5 N, 6 M01. It raises no address-valid.
- R11: Mode codes 11 to 15, pointer modes (codes 0 to 4 and 6) with `rsel` 5 to 7, short displacement with any `rsel` other than 2 or 4, and register load with `rsel`=7 raise `illegal`. They hold `ea_valid` and `wb_en` low and change no register.
- R12: Reset clears R0 to R3, SP and N, sets M01 to 0xFFFF and clears all outputs. A cycle with `op_valid` low leaves `ea_valid`, `wb_en` and `illegal` low and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| mode | input | 4 | Addressing-mode code |
| rsel | input | 3 | Register select |
| disp | input | 16 | Long displacement, absolute address or load value |
| sfld | input | 6 | Short displacement, short absolute or I/O field |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | `ea` is a memory access of the last operation |
| wb_en | output | 1 | A register was written by the last operation |
| wb_sel | output | 3 | Register written |
| wb_data | output | 16 | Value written |
| illegal | output | 1 | Last operation was an illegal mode/register combination |

## Verification
The hardest case to reach is the modulo wrap, in both directions, on R0 and R1. It needs M01, N and a pointer to be set up first, with the pointer placed at the edge of an aligned block. The stimulus gets there through register-load operations. It then steps a pointer past the top of a buffer with post-increment and post-add-offset, uses a negative N with indexed mode to pass below the buffer base, and uses long displacement on R1. The same modifier value is then applied to R2 and to post-decrement on R0, to show that the wrap stays confined to the allowed cases.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int REGSEL_W = 3;
    localparam int NUM_PTR  = 4;
    localparam int MOD_PTRS = 2;   // pointers 0..MOD_PTRS-1 obey the modifier

    localparam logic [REGSEL_W-1:0] SEL_R2  = 3'd2;
    localparam logic [REGSEL_W-1:0] SEL_SP  = 3'd4;
    localparam logic [REGSEL_W-1:0] SEL_N   = 3'd5;
    localparam logic [REGSEL_W-1:0] SEL_M   = 3'd6;
    localparam logic [REGSEL_W-1:0] SEL_BAD = 3'd7;

    typedef enum logic [3:0] {
        MD_IND   = 4'd0,
        MD_PINC  = 4'd1,
        MD_PDEC  = 4'd2,
        MD_PADDN = 4'd3,
        MD_IDXN  = 4'd4,
        MD_SDISP = 4'd5,
        MD_LDISP = 4'd6,
        MD_ABS   = 4'd7,
        MD_ABSS  = 4'd8,
        MD_IOS   = 4'd9,
        MD_LOAD  = 4'd10
    } agu_mode_e;

    typedef enum logic [2:0] {
        ST_ZERO, ST_ONE, ST_MONE, ST_OFS, ST_DISP, ST_PSHORT, ST_MSHORT
    } agu_step_e;

    typedef enum logic [2:0] {
        EA_NONE, EA_PTR, EA_SUM, EA_ABS, EA_ABSS, EA_IOS
    } agu_ea_e;

    typedef struct packed {
        logic      legal;
        logic      wb_sum;   // write pointer+step back
        logic      load;     // write long operand into selected register
        logic      mod_en;   // modifier may apply
        agu_step_e step;
        agu_ea_e   ea_src;
    } agu_dec_t;

endpackage

// File: rtl/agu_decode.sv
module agu_decode
    import agu_pkg::*;
(
    input  logic [3:0]          mode,
    input  logic [REGSEL_W-1:0] rsel,
    output agu_dec_t            dec
);
    logic ptr_ok;
    logic mod_reg;

    assign ptr_ok  = (rsel <= SEL_SP);
    assign mod_reg = (rsel < REGSEL_W'(MOD_PTRS));

    always_comb begin
        dec = '{legal: 1'b0, wb_sum: 1'b0, load: 1'b0, mod_en: 1'b0,
                step: ST_ZERO, ea_src: EA_NONE};
        case (agu_mode_e'(mode))
            MD_IND: begin
                dec.legal  = ptr_ok;
                dec.ea_src = EA_PTR;
            end
            MD_PINC: begin
                dec.legal  = ptr_ok;
                dec.ea_src = EA_PTR;
                dec.step   = ST_ONE;
                dec.wb_sum = 1'b1;
                dec.mod_en = mod_reg;
            end
            MD_PDEC: begin
                dec.legal  = ptr_ok;
                dec.ea_src = EA_PTR;
                dec.step   = ST_MONE;
                dec.wb_sum = 1'b1;
            end
            MD_PADDN: begin
                dec.legal  = ptr_ok;
                dec.ea_src = EA_PTR;
                dec.step   = ST_OFS;
                dec.wb_sum = 1'b1;
                dec.mod_en = mod_reg;
            end
            MD_IDXN: begin
                dec.legal  = ptr_ok;
                dec.ea_src = EA_SUM;
                dec.step   = ST_OFS;
                dec.mod_en = mod_reg;
            end
            MD_SDISP: begin
                dec.legal  = (rsel == SEL_R2) || (rsel == SEL_SP);
                dec.ea_src = EA_SUM;
                dec.step   = (rsel == SEL_SP) ? ST_MSHORT : ST_PSHORT;
            end
            MD_LDISP: begin
                dec.legal  = ptr_ok;
                dec.ea_src = EA_SUM;
                dec.step   = ST_DISP;
                dec.mod_en = mod_reg;
            end
            MD_ABS: begin
                dec.legal  = 1'b1;
                dec.ea_src = EA_ABS;
            end
            MD_ABSS: begin
                dec.legal  = 1'b1;
                dec.ea_src = EA_ABSS;
            end
            MD_IOS: begin
                dec.legal  = 1'b1;
                dec.ea_src = EA_IOS;
            end
            MD_LOAD: begin
                dec.legal  = (rsel != SEL_BAD);
                dec.load   = 1'b1;
            end
            default: dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/agu_modulo.sv
module agu_modulo #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] modm1,
    output logic [AW-1:0] res
);
    localparam int XW = AW + 2;

    logic [AW-1:0]        mask;
    logic signed [XW-1:0] off;
    logic signed [XW-1:0] stp;
    logic signed [XW-1:0] sum;
    logic signed [XW-1:0] lim;
    logic signed [XW-1:0] span;
    logic signed [XW-1:0] fixd;

    always_comb begin
        mask[AW-1] = modm1[AW-1];
        for (int i = AW - 2; i >= 0; i--) begin
            mask[i] = mask[i+1] | modm1[i];
        end
    end

    assign off  = signed'({2'b00, base & mask});
    assign stp  = signed'({{2{step[AW-1]}}, step});
    assign lim  = signed'({2'b00, modm1});
    assign span = lim + XW'(1);
    assign sum  = off + stp;

    always_comb begin
        if (sum < 0)        fixd = sum + span;
        else if (sum > lim) fixd = sum - span;
        else                fixd = sum;
    end

    assign res = (base & ~mask) | (fixd[AW-1:0] & mask);
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile
    import agu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NPTR = NUM_PTR
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [REGSEL_W-1:0]     wsel,
    input  logic [AW-1:0]           wdata,
    output logic [NPTR-1:0][AW-1:0] ptr_q,
    output logic [AW-1:0]           sp_q,
    output logic [AW-1:0]           n_q,
    output logic [AW-1:0]           m_q
);
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)                                   ptr_q[g] <= '0;
            else if (we && wsel == REGSEL_W'(g))       ptr_q[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            n_q  <= '0;
            m_q  <= '1;
        end else if (we) begin
            if (wsel == SEL_SP) sp_q <= wdata;
            if (wsel == SEL_N)  n_q  <= wdata;
            if (wsel == SEL_M)  m_q  <= wdata;
        end
    end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [3:0]          mode,
    input  logic [REGSEL_W-1:0] rsel,
    input  logic [AW-1:0]       disp,
    input  logic [SW-1:0]       sfld,
    output logic [AW-1:0]       ea,
    output logic                ea_valid,
    output logic                wb_en,
    output logic [REGSEL_W-1:0] wb_sel,
    output logic [AW-1:0]       wb_data,
    output logic                illegal
);
    localparam int PW = $clog2(NUM_PTR);

    agu_dec_t                       dec;
    logic [NUM_PTR-1:0][AW-1:0]     ptr_q;
    logic [AW-1:0]                  sp_q, n_q, m_q;
    logic [AW-1:0]                  cur, step_v, lin_sum, mod_sum, sum, ea_d, wdata;
    logic [AW-1:0]                  sfld_z;
    logic                           use_mod, we, accept;

    agu_decode u_dec (.mode(mode), .rsel(rsel), .dec(dec));

    assign sfld_z = {{(AW-SW){1'b0}}, sfld};
    assign cur    = (rsel == SEL_SP) ? sp_q :
                    (rsel < REGSEL_W'(NUM_PTR)) ? ptr_q[rsel[PW-1:0]] : '0;

    always_comb begin
        case (dec.step)
            ST_ONE:    step_v = AW'(1);
            ST_MONE:   step_v = '1;
            ST_OFS:    step_v = n_q;
            ST_DISP:   step_v = disp;
            ST_PSHORT: step_v = sfld_z;
            ST_MSHORT: step_v = AW'(0) - sfld_z;
            default:   step_v = '0;
        endcase
    end

    agu_modulo #(.AW(AW)) u_mod (
        .base(cur), .step(step_v), .modm1(m_q), .res(mod_sum)
    );

    assign lin_sum = cur + step_v;
    assign use_mod = dec.mod_en && (m_q != '1);
    assign sum     = use_mod ? mod_sum : lin_sum;

    always_comb begin
        case (dec.ea_src)
            EA_PTR:  ea_d = cur;
            EA_SUM:  ea_d = sum;
            EA_ABS:  ea_d = disp;
            EA_ABSS: ea_d = sfld_z;
            EA_IOS:  ea_d = {{(AW-SW){1'b1}}, sfld};
            default: ea_d = '0;
        endcase
    end

    assign accept = op_valid && dec.legal;
    assign we     = accept && (dec.wb_sum || dec.load);
    assign wdata  = dec.load ? disp : sum;

    agu_regfile #(.AW(AW), .NPTR(NUM_PTR)) u_rf (
        .clk(clk), .rst(rst), .we(we), .wsel(rsel), .wdata(wdata),
        .ptr_q(ptr_q), .sp_q(sp_q), .n_q(n_q), .m_q(m_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ea       <= '0;
            ea_valid <= 1'b0;
            wb_en    <= 1'b0;
            wb_sel   <= '0;
            wb_data  <= '0;
            illegal  <= 1'b0;
        end else begin
            ea       <= accept ? ea_d : '0;
            ea_valid <= accept && (dec.ea_src != EA_NONE);
            wb_en    <= we;
            wb_sel   <= we ? rsel : '0;
            wb_data  <= we ? wdata : '0;
            illegal  <= op_valid && !dec.legal;
        end
    end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
    parameter int AW = 16,
    parameter int SW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [3:0]    mode,
    input logic [2:0]    rsel,
    input logic [AW-1:0] ea,
    input logic          ea_valid,
    input logic          wb_en,
    input logic          illegal
);
    assert_io_top_R1: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == 4'd9) |=> (ea_valid && (&ea[AW-1:SW]) && !wb_en));

    assert_ind_nowb_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == 4'd0 && rsel <= 3'd4) |=> (ea_valid && !wb_en));

    assert_post_wb_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode >= 4'd1 && mode <= 4'd3 && rsel <= 3'd4) |=> wb_en);

    assert_short_sel_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == 4'd5 && rsel != 3'd2 && rsel != 3'd4) |=> illegal);

    assert_abs_nowb_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (mode == 4'd7 || mode == 4'd8)) |=> (ea_valid && !wb_en));

    assert_ill_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!ea_valid && !wb_en));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!ea_valid && !wb_en && !illegal));
endmodule

bind dsp_agu agu_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .mode(mode), .rsel(rsel),
    .ea(ea), .ea_valid(ea_valid), .wb_en(wb_en), .illegal(illegal)
);

// File: tb/sim_dsp_agu.sv
module sim_dsp_agu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  rsel = '0;
    logic [15:0] disp = '0;
    logic [5:0]  sfld = '0;
    logic [15:0] ea, wb_data;
    logic        ea_valid, wb_en, illegal;
    logic [2:0]  wb_sel;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    dsp_agu u0 (.clk(clk), .rst(rst), .op_valid(op_valid), .mode(mode), .rsel(rsel),
                .disp(disp), .sfld(sfld), .ea(ea), .ea_valid(ea_valid), .wb_en(wb_en),
                .wb_sel(wb_sel), .wb_data(wb_data), .illegal(illegal));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [3:0] m, input logic [2:0] s, input logic [15:0] d, input logic [5:0] f);
        @(negedge clk);
        mode = m; rsel = s; disp = d; sfld = f; op_valid = 1'b1;
        @(posedge clk);
        #1 op_valid = 1'b0;
    endtask

    task automatic load(input logic [2:0] s, input logic [15:0] v);
        op(4'd10, s, v, '0);
    endtask

    task automatic read_ptr(input logic [2:0] s, output logic [15:0] v);
        op(4'd0, s, '0, '0);
        v = ea;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk(!ea_valid && !wb_en && !illegal && ea == 0, "R12 reset outputs", {ea_valid, wb_en, illegal}, 0);
        read_ptr(3'd0, v);
        chk(v == 16'h0000, "R12 R0 reset", v, 0);
        op(4'd1, 3'd0, '0, '0);
        chk(wb_en && wb_data == 16'h0001, "R12 M01 reset linear", wb_data, 1);
    endtask

    task automatic t_io;
        op(4'd9, 3'd6, '0, 6'h3B);
        chk(ea_valid && ea == 16'hFFFB && !wb_en, "R1 io 3B", ea, 16'hFFFB);
        op(4'd9, 3'd0, '0, 6'h00);
        chk(ea == 16'hFFC0, "R1 io 00", ea, 16'hFFC0);
    endtask

    task automatic t_indirect;
        logic [15:0] v;
        load(3'd3, 16'h1234);
        op(4'd0, 3'd3, '0, '0);
        chk(ea_valid && ea == 16'h1234 && !wb_en, "R2 ind R3", ea, 16'h1234);
        read_ptr(3'd3, v);
        chk(v == 16'h1234, "R2 R3 unchanged", v, 16'h1234);
    endtask

    task automatic t_post;
        logic [15:0] v;
        load(3'd1, 16'h4000);
        load(3'd5, 16'h0010);
        op(4'd1, 3'd1, '0, '0);
        chk(ea == 16'h4000 && wb_data == 16'h4001 && wb_sel == 3'd1, "R3 postinc", wb_data, 16'h4001);
        op(4'd2, 3'd1, '0, '0);
        chk(ea == 16'h4001 && wb_data == 16'h4000, "R3 postdec", wb_data, 16'h4000);
        op(4'd3, 3'd1, '0, '0);
        chk(ea == 16'h4000 && wb_data == 16'h4010, "R3 post+N", wb_data, 16'h4010);
        load(3'd4, 16'h0000);
        op(4'd2, 3'd4, '0, '0);
        chk(wb_data == 16'hFFFF && wb_sel == 3'd4, "R3 SP postdec wrap", wb_data, 16'hFFFF);
        read_ptr(3'd1, v);
        chk(v == 16'h4010, "R3 R1 stored", v, 16'h4010);
    endtask

    task automatic t_index;
        logic [15:0] v;
        op(4'd4, 3'd1, '0, '0);
        chk(ea_valid && ea == 16'h4020 && !wb_en, "R4 index N", ea, 16'h4020);
        read_ptr(3'd1, v);
        chk(v == 16'h4010, "R4 R1 unchanged", v, 16'h4010);
    endtask

    task automatic t_short;
        load(3'd2, 16'h1000);
        load(3'd4, 16'h2000);
        op(4'd5, 3'd2, '0, 6'h3F);
        chk(ea_valid && ea == 16'h103F && !wb_en, "R5 R2+short", ea, 16'h103F);
        op(4'd5, 3'd4, '0, 6'h05);
        chk(ea == 16'h1FFB, "R5 SP-short", ea, 16'h1FFB);
        op(4'd5, 3'd0, '0, 6'h05);
        chk(illegal && !ea_valid, "R5 R0 short illegal", illegal, 1);
    endtask

    task automatic t_long;
        op(4'd6, 3'd2, 16'h0F00, '0);
        chk(ea_valid && ea == 16'h1F00 && !wb_en, "R6 R2+long", ea, 16'h1F00);
        op(4'd6, 3'd4, 16'hFFFF, '0);
        chk(ea == 16'h1FFF, "R6 SP+long", ea, 16'h1FFF);
    endtask

    task automatic t_modulo;
        load(3'd6, 16'h0004);
        load(3'd0, 16'h0104);
        op(4'd1, 3'd0, '0, '0);
        chk(ea == 16'h0104 && wb_data == 16'h0100, "R7 postinc wrap top", wb_data, 16'h0100);
        load(3'd5, 16'h0003);
        load(3'd0, 16'h0103);
        op(4'd3, 3'd0, '0, '0);
        chk(wb_data == 16'h0101, "R7 post+N wrap", wb_data, 16'h0101);
        load(3'd5, 16'hFFFE);
        load(3'd0, 16'h0100);
        op(4'd4, 3'd0, '0, '0);
        chk(ea == 16'h0103 && !wb_en, "R7 index neg wrap", ea, 16'h0103);
        load(3'd1, 16'h0202);
        op(4'd6, 3'd1, 16'h0004, '0);
        chk(ea == 16'h0201, "R7 long disp wrap", ea, 16'h0201);
        load(3'd0, 16'h0101);
        op(4'd1, 3'd0, '0, '0);
        chk(wb_data == 16'h0102, "R7 inside buffer", wb_data, 16'h0102);
    endtask

    task automatic t_nomod;
        load(3'd2, 16'h0104);
        op(4'd1, 3'd2, '0, '0);
        chk(wb_data == 16'h0105, "R8 R2 linear", wb_data, 16'h0105);
        load(3'd0, 16'h0100);
        op(4'd2, 3'd0, '0, '0);
        chk(wb_data == 16'h00FF, "R8 postdec linear", wb_data, 16'h00FF);
        load(3'd4, 16'h0104);
        op(4'd1, 3'd4, '0, '0);
        chk(wb_data == 16'h0105, "R8 SP linear", wb_data, 16'h0105);
        load(3'd6, 16'hFFFF);
        load(3'd0, 16'h0104);
        op(4'd1, 3'd0, '0, '0);
        chk(wb_data == 16'h0105, "R7 all ones linear", wb_data, 16'h0105);
    endtask

    task automatic t_abs;
        op(4'd7, 3'd7, 16'hBEEF, 6'h11);
        chk(ea_valid && ea == 16'hBEEF && !wb_en, "R9 absolute", ea, 16'hBEEF);
        op(4'd8, 3'd7, 16'hBEEF, 6'h2A);
        chk(ea == 16'h002A, "R9 abs short", ea, 16'h002A);
    endtask

    task automatic t_load;
        op(4'd10, 3'd5, 16'h0007, '0);
        chk(wb_en && wb_sel == 3'd5 && wb_data == 16'h0007 && !ea_valid, "R10 load N", wb_data, 7);
        load(3'd3, 16'h0100);
        op(4'd4, 3'd3, '0, '0);
        chk(ea == 16'h0107, "R10 N used", ea, 16'h0107);
    endtask

    task automatic t_illegal;
        logic [15:0] v;
        load(3'd0, 16'h0055);
        op(4'd12, 3'd0, '0, '0);
        chk(illegal && !ea_valid && !wb_en, "R11 bad code", illegal, 1);
        op(4'd1, 3'd5, '0, '0);
        chk(illegal && !wb_en, "R11 postinc on N", illegal, 1);
        op(4'd10, 3'd7, 16'h9999, '0);
        chk(illegal && !wb_en, "R11 load sel7", illegal, 1);
        read_ptr(3'd0, v);
        chk(v == 16'h0055, "R11 R0 untouched", v, 16'h0055);
    endtask

    task automatic t_idle;
        logic [15:0] v;
        @(negedge clk);
        mode = 4'd1; rsel = 3'd0; op_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(!ea_valid && !wb_en && !illegal, "R12 idle quiet", {ea_valid, wb_en, illegal}, 0);
        read_ptr(3'd0, v);
        chk(v == 16'h0055, "R12 idle no change", v, 16'h0055);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_io();
        t_indirect();
        t_post();
        t_index();
        t_short();
        t_long();
        t_modulo();
        t_nomod();
        t_abs();
        t_load();
        t_illegal();
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule